// File: doc/BRIEF.md
# Oversampling Tick Generator with Divider and Phase-Accumulator Modes

This block derives the 16x oversampling strobe that a serial transmitter and receiver share from the system clock. It has two engines, and one select input chooses which of them drives the strobe. The first is a reload down-counter, which suits low bit rates. It fires once every N clock cycles, where N is the programmed value and equals clk / (16 * baud). The second is a 16-bit phase accumulator, which suits rates above 19200. Every cycle it adds the programmed value V to a 16-bit sum and fires on each carry out, so the mean tick rate is clk * V / 2^16. Software computes V as baud * 16 * 2^16 / clk.

A run input starts and stops the generator. While run is low, both engines are held in their restart state: the counter is loaded and the accumulator is zero. The first tick after run goes high therefore comes one full period later. The value and the mode select may only be changed while run is low. The strobe is registered and is one clock cycle wide. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `ovs_tick_gen`

## Requirements
- R1: During reset, and after reset is released while run_en is low, os_tick is 0.
- R2: With acc_sel = 0 and baud_val = N >= 2, os_tick is high in the cycle after the m-th rising edge that samples run_en high exactly when m is a multiple of N. m counts edges since the last edge that sampled run_en low, so the first tick follows edge N.
- R3: Each tick lasts exactly one clock cycle. With acc_sel = 0 and N >= 2, two consecutive cycles never both carry a tick.
- R4: With acc_sel = 0 and baud_val equal to 0 or 1, os_tick is high in the cycle after every edge that samples run_en high.
- R5: After an edge that samples run_en low, os_tick is 0 in the next cycle. A later enable restarts the count at m = 1, so a full period passes before the first tick.
- R6: With acc_sel = 1 and baud_val = V, os_tick is high after the m-th running edge exactly when floor(m*V/65536) > floor((m-1)*V/65536). Over M running edges from an enable, the number of ticks is floor(M*V/65536).
- R7: With acc_sel = 1 and baud_val = 0, os_tick stays 0.
- R8: With acc_sel = 1 and V <= 0x8000, two consecutive cycles never both carry a tick. V = 0x8000 gives a tick on every second cycle.
- R9: acc_sel = 1 selects the accumulator and acc_sel = 0 selects the counter. The engine that is not selected is held in its restart state, so after a mode change made while stopped, the first period in the new mode is a full one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_en | input | 1 | Generator runs while high; both engines restart while low |
| acc_sel | input | 1 | 1 selects the phase accumulator, 0 selects the down-counter |
| baud_val | input | 16 | Divisor (counter mode) or phase increment (accumulator mode); change only while stopped |
| os_tick | output | 1 | One-cycle oversampling strobe |

## Verification
The strobe is registered. The tick belonging to the m-th edge that samples run_en high is therefore visible after that same edge, and a drop of run_en shows as a quiet output after the next edge. Reset release passes through two synchroniser stages, so the bench keeps run_en low for several cycles first. The bench drives its inputs 4 ns after a rising edge and, for that cycle, queues one expected strobe value computed from the closed-form tick position of each mode. The monitor pops that value at the following falling edge, so every cycle is compared exactly once, in order. After each window, the tick total is also compared with the whole-window count formula.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

  typedef enum logic {
    OVS_MODE_DIV = 1'b0,
    OVS_MODE_ACC = 1'b1
  } ovs_mode_e;

endpackage

// File: rtl/ovs_div_cnt.sv
// Reload down-counter engine: fires once every max(val,1) enabled cycles.
module ovs_div_cnt #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VAL_W-1:0] val,
  output logic             hit
);

  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  logic [VAL_W-1:0] cnt_q;
  logic [VAL_W-1:0] cnt_d;
  logic [VAL_W-1:0] reload;

  always_comb begin
    // period is max(val,1); the counter holds period-1 down to 0
    reload = (val > ONE) ? (val - ONE) : '0;
    hit    = en && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (!en || hit) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ovs_phase_acc.sv
// Phase accumulator engine: fires on each carry out of acc + val.
module ovs_phase_acc #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VAL_W-1:0] val,
  output logic             hit
);

  logic [VAL_W-1:0] acc_q;
  logic [VAL_W-1:0] acc_d;
  logic [VAL_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, val};
    hit   = en && sum[VAL_W];
    acc_d = en ? sum[VAL_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/ovs_tick_gen.sv
module ovs_tick_gen
  import ovs_pkg::*;
#(
  parameter int VAL_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             acc_sel,
  input  logic [VAL_W-1:0] baud_val,
  output logic             os_tick
);

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ovs_mode_e mode;
  logic      div_en;
  logic      acc_en;
  logic      div_hit;
  logic      acc_hit;
  logic      tick_d;
  logic      tick_q;

  always_comb begin
    mode   = ovs_mode_e'(acc_sel);
    div_en = run_en && (mode == OVS_MODE_DIV);
    acc_en = run_en && (mode == OVS_MODE_ACC);
    tick_d = div_hit || acc_hit;
  end

  ovs_div_cnt #(.VAL_W(VAL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (div_en),
    .val   (baud_val),
    .hit   (div_hit)
  );

  ovs_phase_acc #(.VAL_W(VAL_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (acc_en),
    .val   (baud_val),
    .hit   (acc_hit)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign os_tick = tick_q;

endmodule

// File: rtl/ovs_tick_chk.sv
module ovs_tick_chk #(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             acc_sel,
  input logic [VAL_W-1:0] baud_val,
  input logic             os_tick
);

  localparam logic [VAL_W-1:0] ONE  = VAL_W'(1);
  localparam logic [VAL_W-1:0] HALF = VAL_W'(1) << (VAL_W - 1);

  // R5: a stopped generator is quiet in the next cycle
  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !os_tick);

  // R3: counter mode, N >= 2, never two ticks back to back
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && run_en && !acc_sel && $past(!acc_sel) && (baud_val > ONE) && $stable(baud_val))
      |=> !os_tick);

  // R4: counter value 0 or 1 ticks on every running cycle
  a_r4_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !acc_sel && (baud_val <= ONE) && ($past(baud_val) <= ONE) && $past(rst_n))
      |=> os_tick);

  // R7: zero increment never carries
  a_r7_zero_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && acc_sel && (baud_val == '0)) |=> !os_tick);

  // R8: increment at most half never gives consecutive carries
  a_r8_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && run_en && acc_sel && $past(acc_sel) && $past(run_en) && (baud_val <= HALF) && $stable(baud_val))
      |=> !os_tick);

endmodule

bind ovs_tick_gen ovs_tick_chk #(.VAL_W(VAL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .acc_sel  (acc_sel),
  .baud_val (baud_val),
  .os_tick  (os_tick)
);

// File: tb/sim_ovs_tick_gen.sv
`timescale 1ns/1ps
module sim_ovs_tick_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic        acc_sel;
  logic [15:0] baud_val;
  logic        os_tick;

  always #10 clk = ~clk;

  ovs_tick_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .acc_sel  (acc_sel),
    .baud_val (baud_val),
    .os_tick  (os_tick)
  );

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    tick_seen = 0;
  int    m_run = 0;
  bit    mdl_acc = 1'b0;
  int    mdl_val = 0;
  bit    done = 1'b0;

  function automatic bit exp_tick(int m, bit acc, int v);
    longint a;
    longint b;
    int     n;
    if (m == 0) return 1'b0;
    if (!acc) begin
      n = (v < 1) ? 1 : v;
      return (m % n) == 0;
    end
    a = (longint'(m) * longint'(v)) >>> 16;
    b = (longint'(m - 1) * longint'(v)) >>> 16;
    return a != b;
  endfunction

  // monitor: one queued expectation per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (os_tick === 1'b1) tick_seen++;
      if (os_tick !== it.exp) begin
        n_fail++;
        $display("FAIL %s: os_tick actual %b expected %b at %0t", it.tag, os_tick, it.exp, $time);
      end
    end
  end

  // one cycle: queue expectation for this cycle, drive next inputs
  task automatic step(input string tag, input bit nrun);
    item_t it;
    it.exp = exp_tick(m_run, mdl_acc, mdl_val);
    it.tag = tag;
    sb_q.push_back(it);
    run_en = nrun;
    @(posedge clk);
    m_run   = run_en ? m_run + 1 : 0;
    mdl_acc = acc_sel;
    mdl_val = int'(baud_val);
    #4;
  endtask

  task automatic count_check(input string tag, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s: tick count actual %0d expected %0d", tag, got, want);
    end
  endtask

  task automatic window(input bit acc, input int v, input int cycles, input string tag);
    longint want;
    acc_sel  = acc;
    baud_val = 16'(v);
    step(tag, 1'b0);
    tick_seen = 0;
    for (int i = 0; i < cycles; i++) step(tag, 1'b1);
    for (int i = 0; i < 3; i++) step("R5", 1'b0);
    if (acc) want = (longint'(cycles) * longint'(v)) >>> 16;
    else     want = cycles / ((v < 1) ? 1 : v);
    count_check(acc ? "R6" : "R2", tick_seen, int'(want));
  endtask

  initial begin
    rst_n    = 1'b0;
    run_en   = 1'b0;
    acc_sel  = 1'b0;
    baud_val = 16'd5;
    repeat (3) @(posedge clk);
    #4;
    n_chk++;
    if (os_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: os_tick in reset actual %b expected 0", os_tick);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step("R1", 1'b0);

    window(1'b0, 5, 23, "R2");
    window(1'b0, 5, 12, "R5");
    window(1'b0, 2, 9, "R3");
    window(1'b0, 1, 6, "R4");
    window(1'b0, 0, 6, "R4");
    window(1'b1, 16'h8000, 20, "R8");
    window(1'b1, 16'h6000, 40, "R6");
    window(1'b1, 0, 30, "R7");
    window(1'b1, 16'hC000, 16, "R6");
    window(1'b1, 16'h0123, 2000, "R6");
    window(1'b0, 3, 10, "R9");
    window(1'b1, 16'h4000, 12, "R9");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule